// File: doc/BRIEF.md
# Four-Bit Eight-Function Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit for narrow operands. Two operands and a three-bit function code go in. Out come a result word, a carry from the top bit position and a flag for signed two's-complement overflow. The eight functions are split into three groups. Three are arithmetic: a sum and the two differences. Three are bitwise. Two are constants: all zeros and all ones.

All three arithmetic functions share one adder with a carry input at the least significant bit. The two differences are formed by adding the bitwise complement of the subtrahend to the minuend. The caller therefore drives the carry input high to obtain a true difference, and drives it low to obtain a plain sum.

The block holds no state and has no clock. Every function code yields fully defined outputs.

Top module: `nibble_alu`

## Requirements
- R1: Function code 3'b000 (clear) drives the result to all zeros.
- R2: Function code 3'b111 (preset) drives the result to all ones.
- R3: Function code 3'b011 (add) gives {carry out, result} = A + B + carry in, so carry in = 0 yields the plain sum.
- R4: Function code 3'b010 (A minus B) gives {carry out, result} = A + ~B + carry in, so carry in = 1 yields A - B modulo 16, with carry out = 1 exactly when A >= B.
- R5: Function code 3'b001 (B minus A) gives {carry out, result} = B + ~A + carry in, so carry in = 1 yields B - A modulo 16.
- R6: For the three arithmetic codes, the overflow flag is 1 exactly when the signed sum of the two adder inputs plus carry in lies outside -8..7. The adder inputs are the minuend and the complemented subtrahend, or A and B for the add code.
- R7: Function codes 3'b100, 3'b101 and 3'b110 give the bitwise XOR, OR and AND of A and B respectively.
- R8: For the clear, preset and bitwise codes, carry out and overflow are 0 and the carry input has no effect on any output.
- R9: The outputs depend only on the present inputs: the same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | Operand A |
| opb_i | input | 4 | Operand B |
| func_i | input | 3 | Function code |
| cin_i | input | 1 | Carry into the least significant bit |
| res_o | output | 4 | Result word |
| cout_o | output | 1 | Carry out of the most significant bit |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The full input space (every function code, every operand pair and both carry values) is swept, so each arithmetic code is tried at its wrap points. Sign-boundary pairs such as 7+1 and -8-1 show whether overflow is taken from the carries at the top bit or from the carry out alone. Sweeping both carry values separates the correct carry injection for the differences from an off-by-one. On the bitwise and constant codes, the same sweep shows that the flags stay low and that the carry input is ignored. Seeded random vectors replayed after differing histories confirm that no state is kept between vectors.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

    localparam int unsigned FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        OP_CLEAR   = 3'b000,
        OP_B_SUB_A = 3'b001,
        OP_A_SUB_B = 3'b010,
        OP_ADD     = 3'b011,
        OP_XOR     = 3'b100,
        OP_OR      = 3'b101,
        OP_AND     = 3'b110,
        OP_PRESET  = 3'b111
    } alu_op_e;

    function automatic logic op_is_arith(alu_op_e op);
        return (op == OP_B_SUB_A) || (op == OP_A_SUB_B) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/nalu_operand_steer.sv
module nalu_operand_steer
    import nalu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] addend_x,
    output logic [W-1:0] addend_y
);

    // Choose the adder inputs: the minuend passes straight through and the
    // subtrahend is complemented; the carry input finishes the negation.
    always_comb begin
        unique case (op)
            OP_B_SUB_A: begin
                addend_x = opb;
                addend_y = ~opa;
            end
            OP_A_SUB_B: begin
                addend_x = opa;
                addend_y = ~opb;
            end
            OP_ADD: begin
                addend_x = opa;
                addend_y = opb;
            end
            default: begin
                addend_x = '0;
                addend_y = '0;
            end
        endcase
    end

endmodule

// File: rtl/nalu_ripple_chain.sv
module nalu_ripple_chain #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         carry_into_msb,
    output logic         carry_out
);

    logic [W:0] carry;

    assign carry[0] = cin;

    // One full adder per bit, carries rippling upward.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p          = x[i] ^ y[i];
        assign sum[i]     = p ^ carry[i];
        assign carry[i+1] = (x[i] & y[i]) | (p & carry[i]);
    end

    assign carry_into_msb = carry[W-1];
    assign carry_out      = carry[W];

endmodule

// File: rtl/nalu_bitwise.sv
module nalu_bitwise
    import nalu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  alu_op_e      op,
    output logic [W-1:0] bits
);

    always_comb begin
        unique case (op)
            OP_XOR:    bits = opa ^ opb;
            OP_OR:     bits = opa | opb;
            OP_AND:    bits = opa & opb;
            OP_PRESET: bits = '1;
            default:   bits = '0;
        endcase
    end

endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
    import nalu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0]      opa_i,
    input  logic [W-1:0]      opb_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic              cin_i,
    output logic [W-1:0]      res_o,
    output logic              cout_o,
    output logic              ovf_o
);

    alu_op_e      op;
    logic [W-1:0] add_x;
    logic [W-1:0] add_y;
    logic [W-1:0] add_sum;
    logic         add_c_msb;
    logic         add_c_out;
    logic [W-1:0] logic_bits;
    logic         arith;

    assign op    = alu_op_e'(func_i);
    assign arith = op_is_arith(op);

    nalu_operand_steer #(.W(W)) u_steer (
        .opa      (opa_i),
        .opb      (opb_i),
        .op       (op),
        .addend_x (add_x),
        .addend_y (add_y)
    );

    nalu_ripple_chain #(.W(W)) u_adder (
        .x              (add_x),
        .y              (add_y),
        .cin            (cin_i),
        .sum            (add_sum),
        .carry_into_msb (add_c_msb),
        .carry_out      (add_c_out)
    );

    nalu_bitwise #(.W(W)) u_bitwise (
        .opa  (opa_i),
        .opb  (opb_i),
        .op   (op),
        .bits (logic_bits)
    );

    always_comb begin
        if (arith) begin
            res_o  = add_sum;
            cout_o = add_c_out;
            ovf_o  = add_c_msb ^ add_c_out;
        end else begin
            res_o  = logic_bits;
            cout_o = 1'b0;
            ovf_o  = 1'b0;
        end
    end

endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk
    import nalu_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input logic [W-1:0]      opa_i,
    input logic [W-1:0]      opb_i,
    input logic [FUNC_W-1:0] func_i,
    input logic              cin_i,
    input logic [W-1:0]      res_o,
    input logic              cout_o,
    input logic              ovf_o
);

    logic [W:0]   wide_sum;
    logic [W:0]   wide_amb;
    logic [W:0]   wide_bma;
    logic [W-1:0] nb;
    logic [W-1:0] na;

    assign nb       = ~opb_i;
    assign na       = ~opa_i;
    assign wide_sum = {1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, cin_i};
    assign wide_amb = {1'b0, opa_i} + {1'b0, nb} + {{W{1'b0}}, cin_i};
    assign wide_bma = {1'b0, opb_i} + {1'b0, na} + {{W{1'b0}}, cin_i};

    always_comb begin
        if (func_i == OP_CLEAR)
            AST_CLEAR_ZERO: assert (res_o == '0) else $error("clear result nonzero"); // R1
        if (func_i == OP_PRESET)
            AST_PRESET_ONES: assert (res_o == '1) else $error("preset result not ones"); // R2
        if (func_i == OP_ADD)
            AST_ADD_SUM: assert ({cout_o, res_o} == wide_sum) else $error("add mismatch"); // R3
        if (func_i == OP_A_SUB_B)
            AST_AMB_DIFF: assert ({cout_o, res_o} == wide_amb) else $error("a-b mismatch"); // R4
        if (func_i == OP_B_SUB_A)
            AST_BMA_DIFF: assert ({cout_o, res_o} == wide_bma) else $error("b-a mismatch"); // R5
        if (func_i == OP_ADD)
            AST_ADD_OVF_SIGN: assert (ovf_o == ((opa_i[W-1] == opb_i[W-1]) && (res_o[W-1] != opa_i[W-1]))) else $error("add overflow flag"); // R6
        if (func_i == OP_A_SUB_B)
            AST_AMB_OVF_SIGN: assert (ovf_o == ((opa_i[W-1] == nb[W-1]) && (res_o[W-1] != opa_i[W-1]))) else $error("a-b overflow flag"); // R6
        if (func_i == OP_OR)
            AST_OR_COVERS: assert (((res_o & opa_i) == opa_i) && ((res_o & opb_i) == opb_i)) else $error("or result"); // R7
        if (!op_is_arith(alu_op_e'(func_i)))
            AST_FLAGS_QUIET: assert (!cout_o && !ovf_o) else $error("flags set on non-arith code"); // R8
    end

endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_nibble_alu_chk (
    .opa_i  (opa_i),
    .opb_i  (opb_i),
    .func_i (func_i),
    .cin_i  (cin_i),
    .res_o  (res_o),
    .cout_o (cout_o),
    .ovf_o  (ovf_o)
);

// File: tb/test_nibble_alu.sv
module test_nibble_alu;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   s;
    logic         c;
    logic [W-1:0] f;
    logic         co;
    logic         ov;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nibble_alu #(.W(W)) i_nibble_alu (
        .opa_i  (a),
        .opb_i  (b),
        .func_i (s),
        .cin_i  (c),
        .res_o  (f),
        .cout_o (co),
        .ovf_o  (ov)
    );

    // Reference: returns {cout, ovf, f[3:0]}
    function automatic logic [5:0] ref_model(int ai, int bi, int si, int ci);
        int x, y, sum, sx, sy, ss;
        logic [3:0] rf;
        logic rc, ro;
        rc = 1'b0;
        ro = 1'b0;
        rf = 4'd0;
        if (si == 1 || si == 2 || si == 3) begin
            if (si == 3)      begin x = ai; y = bi;      end
            else if (si == 2) begin x = ai; y = 15 - bi; end
            else              begin x = bi; y = 15 - ai; end
            sum = x + y + ci;
            rf  = 4'(sum % 16);
            rc  = (sum >= 16);
            sx  = (x >= 8) ? x - 16 : x;
            sy  = (y >= 8) ? y - 16 : y;
            ss  = sx + sy + ci;
            ro  = (ss > 7) || (ss < -8);
        end else if (si == 0) rf = 4'd0;
        else if (si == 7)     rf = 4'hF;
        else if (si == 4)     rf = 4'(ai ^ bi);
        else if (si == 5)     rf = 4'(ai | bi);
        else                  rf = 4'(ai & bi);
        return {rc, ro, rf};
    endfunction

    function automatic string req_of(int si);
        case (si)
            0: return "R1";
            1: return "R5";
            2: return "R4";
            3: return "R3";
            7: return "R2";
            default: return "R7";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(int ai, int bi, int si, int ci);
        logic [5:0] e;
        @(posedge clk);
        a = 4'(ai); b = 4'(bi); s = 3'(si); c = 1'(ci);
        @(negedge clk);
        e = ref_model(ai, bi, si, ci);
        check(req_of(si), "result", int'(f), int'(e[3:0]));
        if (si == 1 || si == 2 || si == 3) begin
            check(req_of(si), "carry", int'(co), int'(e[5]));
            check("R6", "overflow", int'(ov), int'(e[4]));
        end else begin
            check("R8", "carry", int'(co), 0);
            check("R8", "overflow", int'(ov), 0);
        end
    endtask

    initial begin
        a = '0; b = '0; s = '0; c = 1'b0;
        // Initial state: all-zero inputs, clear code
        @(negedge clk);
        check("R1", "initial result", int'(f), 0);
        check("R8", "initial carry", int'(co), 0);

        // Directed corners
        apply(7, 1, 3, 0);   // R3/R6 positive overflow
        apply(8, 8, 3, 0);   // R3 carry and negative overflow
        apply(8, 1, 2, 1);   // R4 -8-1 overflow
        apply(3, 3, 2, 1);   // R4 equal operands, carry 1
        apply(2, 3, 2, 1);   // R4 borrow, carry 0
        apply(5, 2, 1, 1);   // R5 borrow
        apply(15, 15, 7, 1); // R2
        apply(15, 15, 0, 1); // R1 with carry in high
        apply(10, 12, 4, 1); // R7/R8 carry ignored

        // Exhaustive sweep
        for (int si = 0; si < 8; si++)
            for (int ai = 0; ai < 16; ai++)
                for (int bi = 0; bi < 16; bi++)
                    for (int ci = 0; ci < 2; ci++)
                        apply(ai, bi, si, ci);

        // R8: carry input has no effect on non-arithmetic codes
        for (int si = 4; si < 8; si++) begin
            logic [W-1:0] f0;
            apply(9, 6, si, 0);
            f0 = f;
            apply(9, 6, si, 1);
            check("R8", "carry-in independence", int'(f), int'(f0));
        end

        // R9: random vectors re-applied after a different history
        void'($urandom(32'd20240611));
        for (int k = 0; k < 600; k++) begin
            int ai, bi, si, ci;
            logic [W-1:0] f1;
            logic co1, ov1;
            ai = int'($urandom % 16); bi = int'($urandom % 16);
            si = int'($urandom % 8);  ci = int'($urandom % 2);
            apply(ai, bi, si, ci);
            f1 = f; co1 = co; ov1 = ov;
            apply(int'($urandom % 16), int'($urandom % 16), int'($urandom % 8), int'($urandom % 2));
            apply(ai, bi, si, ci);
            check("R9", "replay result", int'(f), int'(f1));
            check("R9", "replay flags", int'({co, ov}), int'({co1, ov1}));
        end

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule